// File: doc/BRIEF.md
# Descriptor-Table Bus-Master DMA Engine

This block moves sector data between a storage device and system memory without processor involvement. Software writes the byte address of a descriptor table and then sets a start bit. The engine reads descriptors one at a time, and each descriptor names a buffer in memory and its length. It then streams 16-bit words between the device handshake and the memory master port until the table is used up, the device reports that it is finished, software stops it, or memory returns an error.

Software reaches three registers through a small byte-addressed I/O port. Reads return data one cycle after the read strobe. The final status shows how the table length compared with the device's transfer. If the table ran out early, the status is 0. If the table matched the transfer, the status is interrupt only. If the table was longer than the transfer, the status is interrupt with active still set. A memory fault gives error plus interrupt. The `irq` output mirrors the interrupt status bit.

The memory port carries one access at a time. A request stays asserted with a stable address until a one-cycle `mem_ack`, which may carry `mem_err`. Read data and write data sit in the low lanes for the requested address. A data write stores 16 bits.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset, all three registers read 0, `irq` is 0, and `mem_req`, `dev_rready` and `dev_wvalid` are low.
- R2: The register offsets are as follows. Offset 4 is a 32-bit table base that reads back as written. Offset 0 reads back bit 0 (run) and bit 3 (direction, 1 = device to memory). Offset 2 reads bit 0 active, bit 1 error and bit 2 interrupt.
- R3: Writing offset 0 with bit 0 set while idle sets active and fetches descriptors from the base, 8 bytes each. Word 0 holds the buffer address. Word 1 holds the byte count in bits 15:0 and the last-entry flag in bit 31. Descriptors are read in order until a flagged entry is used up.
- R4: In device-to-memory mode, each word accepted from the device is written to memory at the buffer address, which rises by 2 per word and continues into the next descriptor's buffer.
- R5: In memory-to-device mode, memory words are read in the same address order and presented to the device.
- R6: When the table exactly covers the device transfer, the final status is 0x04.
- R7: When the table ends before the device finishes, active clears without an interrupt and the status is 0x00. This also holds when software stops it first and the device never completes.
- R8: When the device signals done while table bytes remain, interrupt sets and active stays set, giving status 0x05.
- R9: Writing offset 0 with bit 0 clear drops active and ends all memory and device handshakes. A later device done gives status 0x04.
- R10: Writing 1 to status bit 2 or bit 1 clears that bit, and writing 0 leaves it. Device done sets interrupt, and `irq` always equals the interrupt bit.
- R11: An error response on the memory port gives status 0x06 (error and interrupt set, active clear).
- R12: A descriptor count field of 0 means 65536 bytes.
- R13: A memory request keeps its address and write flag until acknowledged. `mem_req`, `dev_rready` and `dev_wvalid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we | input | 1 | Register write strobe |
| io_re | input | 1 | Register read strobe |
| io_addr | input | 3 | Register byte offset |
| io_wdata | input | 32 | Register write data |
| io_rdata | output | 32 | Register read data, valid the cycle after `io_re` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a 16-bit write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (low 16 bits used) |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle access completion |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| dev_rvalid | input | 1 | Device offers a word toward memory |
| dev_rready | output | 1 | Engine accepts the device word |
| dev_rdata | input | 16 | Word from the device |
| dev_wvalid | output | 1 | Engine offers a word to the device |
| dev_wready | input | 1 | Device accepts the word |
| dev_wdata | output | 16 | Word to the device |
| dev_done | input | 1 | Device finished its transfer (its interrupt) |
| irq | output | 1 | Interrupt line |

## Verification
The hardest states to reach are those where the descriptor table and the device disagree about the transfer length. These are the table outliving the device, which leaves active and interrupt both set, and a stop followed later by a completion. A real device decides its own length, so the bench's device model takes a word count independent of the descriptor counts. It raises done only after its last handshake, and the bench can also inject a done pulse directly after a software stop. A vector table combines these lengths with stop requests. Separate directed cases force an error response at a chosen descriptor address.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int unsigned REG_CMD = 0;
  localparam int unsigned REG_STS = 2;
  localparam int unsigned REG_PTR = 4;

  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;
  localparam int STS_ACT   = 0;
  localparam int STS_ERR   = 1;
  localparam int STS_IRQ   = 2;
  localparam int DESC_LAST = 31;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_DADDR, SQ_DCNT, SQ_DEVIN, SQ_MEMWR, SQ_MEMRD, SQ_DEVOUT
  } sq_state_t;
endpackage

// File: rtl/prd_regs.sv
module prd_regs
  import prd_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_we,
  input  logic          io_re,
  input  logic [2:0]    io_addr,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  input  logic          dev_done,
  input  logic          tbl_end,
  input  logic          mem_fault,
  output logic          go,
  output logic          halt,
  output logic          to_mem,
  output logic [AW-1:0] tbl_base,
  output logic          active,
  output logic          irq
);
  logic start_q, err_q, intr_q;
  logic wr_cmd, wr_sts, wr_ptr;

  assign wr_cmd = io_we && (io_addr == 3'(REG_CMD));
  assign wr_sts = io_we && (io_addr == 3'(REG_STS));
  assign wr_ptr = io_we && (io_addr == 3'(REG_PTR));
  assign go     = wr_cmd && io_wdata[CMD_GO] && !active;
  assign halt   = wr_cmd && !io_wdata[CMD_GO];
  assign irq    = intr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      to_mem   <= 1'b0;
      tbl_base <= '0;
      active   <= 1'b0;
      err_q    <= 1'b0;
      intr_q   <= 1'b0;
      io_rdata <= '0;
    end else begin
      if (wr_cmd) start_q <= io_wdata[CMD_GO];
      if (wr_cmd && !active) to_mem <= io_wdata[CMD_TOMEM];
      if (wr_ptr) tbl_base <= io_wdata[AW-1:0];

      if (halt) active <= 1'b0;
      else if (go) active <= 1'b1;
      else if (tbl_end || mem_fault) active <= 1'b0;

      if (mem_fault) err_q <= 1'b1;
      else if (wr_sts && io_wdata[STS_ERR]) err_q <= 1'b0;

      if (dev_done || mem_fault) intr_q <= 1'b1;
      else if (wr_sts && io_wdata[STS_IRQ]) intr_q <= 1'b0;

      if (io_re) begin
        case (io_addr)
          3'(REG_CMD): io_rdata <= {28'd0, to_mem, 2'd0, start_q};
          3'(REG_STS): io_rdata <= {29'd0, intr_q, err_q, active};
          3'(REG_PTR): io_rdata <= 32'(tbl_base);
          default:     io_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_seq.sv
module prd_seq
  import prd_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          halt,
  input  logic          to_mem,
  input  logic [AW-1:0] tbl_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic          dev_rvalid,
  output logic          dev_rready,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wvalid,
  input  logic          dev_wready,
  output logic [DW-1:0] dev_wdata,
  output logic          tbl_end,
  output logic          mem_fault
);
  localparam int STEP = DW / 8;
  localparam int RW   = CW + 1;

  sq_state_t      st;
  logic [AW-1:0]  dptr, baddr;
  logic [RW-1:0]  remain;
  logic           last_desc;
  logic [DW-1:0]  word;
  logic           step, fin;

  function automatic logic [RW-1:0] decode_len(input logic [31:0] w);
    logic [CW-1:0] f;
    f = w[CW-1:0] & ~CW'(STEP - 1);
    return (f == '0) ? (RW'(1) << CW) : {1'b0, f};
  endfunction

  assign step       = (st == SQ_MEMWR && mem_ack && !mem_err) ||
                      (st == SQ_DEVOUT && dev_wready);
  assign fin        = (remain == RW'(STEP));
  assign dev_rready = (st == SQ_DEVIN);
  assign dev_wvalid = (st == SQ_DEVOUT);
  assign dev_wdata  = word;
  assign mem_wdata  = 32'(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      dptr      <= '0;
      baddr     <= '0;
      remain    <= '0;
      last_desc <= 1'b0;
      word      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      tbl_end   <= 1'b0;
      mem_fault <= 1'b0;
    end else begin
      tbl_end   <= 1'b0;
      mem_fault <= 1'b0;
      if (halt) begin
        st      <= SQ_IDLE;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end else if (step) begin
        baddr  <= baddr + AW'(STEP);
        remain <= remain - RW'(STEP);
        mem_we <= 1'b0;
        if (fin && last_desc) begin
          tbl_end <= 1'b1;
          mem_req <= 1'b0;
          st      <= SQ_IDLE;
        end else if (fin) begin
          mem_addr <= dptr;
          mem_req  <= 1'b1;
          st       <= SQ_DADDR;
        end else if (to_mem) begin
          mem_req <= 1'b0;
          st      <= SQ_DEVIN;
        end else begin
          mem_addr <= baddr + AW'(STEP);
          mem_req  <= 1'b1;
          st       <= SQ_MEMRD;
        end
      end else begin
        case (st)
          SQ_IDLE: if (go) begin
            dptr     <= tbl_base;
            mem_addr <= tbl_base;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            st       <= SQ_DADDR;
          end
          SQ_DADDR: if (mem_ack) begin
            if (mem_err) begin
              mem_fault <= 1'b1;
              mem_req   <= 1'b0;
              st        <= SQ_IDLE;
            end else begin
              baddr    <= mem_rdata[AW-1:0] & ~AW'(STEP - 1);
              mem_addr <= dptr + AW'(4);
              st       <= SQ_DCNT;
            end
          end
          SQ_DCNT: if (mem_ack) begin
            if (mem_err) begin
              mem_fault <= 1'b1;
              mem_req   <= 1'b0;
              st        <= SQ_IDLE;
            end else begin
              remain    <= decode_len(mem_rdata);
              last_desc <= mem_rdata[DESC_LAST];
              dptr      <= dptr + AW'(8);
              if (to_mem) begin
                mem_req <= 1'b0;
                st      <= SQ_DEVIN;
              end else begin
                mem_addr <= baddr;
                st       <= SQ_MEMRD;
              end
            end
          end
          SQ_DEVIN: if (dev_rvalid) begin
            word     <= dev_rdata;
            mem_addr <= baddr;
            mem_we   <= 1'b1;
            mem_req  <= 1'b1;
            st       <= SQ_MEMWR;
          end
          SQ_MEMWR: if (mem_ack && mem_err) begin
            mem_fault <= 1'b1;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            st        <= SQ_IDLE;
          end
          SQ_MEMRD: if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              mem_fault <= 1'b1;
              st        <= SQ_IDLE;
            end else begin
              word <= mem_rdata[DW-1:0];
              st   <= SQ_DEVOUT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_we,
  input  logic          io_re,
  input  logic [2:0]    io_addr,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic          dev_rvalid,
  output logic          dev_rready,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wvalid,
  input  logic          dev_wready,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_done,
  output logic          irq
);
  logic          go_w, halt_w, to_mem_w, active_w, tbl_end_w, fault_w;
  logic [AW-1:0] base_w;

  prd_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .io_we(io_we), .io_re(io_re), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_done(dev_done),
    .tbl_end(tbl_end_w), .mem_fault(fault_w), .go(go_w), .halt(halt_w),
    .to_mem(to_mem_w), .tbl_base(base_w), .active(active_w), .irq(irq)
  );

  prd_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .go(go_w), .halt(halt_w), .to_mem(to_mem_w),
    .tbl_base(base_w), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .dev_rvalid(dev_rvalid),
    .dev_rready(dev_rready), .dev_rdata(dev_rdata), .dev_wvalid(dev_wvalid),
    .dev_wready(dev_wready), .dev_wdata(dev_wdata), .tbl_end(tbl_end_w),
    .mem_fault(fault_w)
  );
endmodule

// File: rtl/prd_dma_checks.sv
module prd_dma_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          halt,
  input logic          tbl_end,
  input logic          fault,
  input logic          active,
  input logic          irq,
  input logic          dev_done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          dev_rready,
  input logic          dev_wvalid
);
  // R9: a stop ends every handshake on the next cycle
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!mem_req && !dev_rready && !dev_wvalid));

  // R11: a memory fault leaves active clear and interrupt set
  a_r11_fault_status: assert property (@(posedge clk) disable iff (rst)
    (fault && !go) |=> (!active && irq));

  // R7: end of table drops active
  a_r7_table_end: assert property (@(posedge clk) disable iff (rst)
    (tbl_end && !go) |=> !active);

  // R10: device completion raises the interrupt line
  a_r10_done_irq: assert property (@(posedge clk) disable iff (rst)
    dev_done |=> irq);

  // R13: request held stable until acknowledged
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !halt) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R13: only one side of the engine busy at a time
  a_r13_one_side: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req, dev_rready, dev_wvalid}));
endmodule

bind prd_dma_engine prd_dma_checks #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .go(go_w), .halt(halt_w), .tbl_end(tbl_end_w),
  .fault(fault_w), .active(active_w), .irq(irq), .dev_done(dev_done),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .dev_rready(dev_rready), .dev_wvalid(dev_wvalid)
);

// File: tb/prd_dma_engine_test.sv
module prd_dma_engine_test;
  localparam int RC = 0, RS = 2, RP = 4;

  typedef struct packed {
    logic        dir;    // 1 = device to memory
    logic        two;    // two descriptors
    logic [15:0] c0;
    logic [15:0] c1;
    logic [15:0] nw;     // device word count
    logic        abort;
    logic        kick;   // inject done after stop
    logic [2:0]  exp;
    logic        chk;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 16'd512,    16'd0,   16'd256, 1'b0, 1'b0, 3'd4, 1'b1},
    '{1'b1, 1'b0, 16'd16,     16'd0,   16'd256, 1'b0, 1'b0, 3'd0, 1'b0},
    '{1'b1, 1'b0, 16'h1000,   16'd0,   16'd256, 1'b0, 1'b0, 3'd5, 1'b1},
    '{1'b1, 1'b0, 16'h1000,   16'd0,   16'd256, 1'b1, 1'b1, 3'd4, 1'b0},
    '{1'b1, 1'b0, 16'd16,     16'd0,   16'd256, 1'b1, 1'b0, 3'd0, 1'b0},
    '{1'b0, 1'b0, 16'd512,    16'd0,   16'd256, 1'b0, 1'b0, 3'd4, 1'b1},
    '{1'b1, 1'b1, 16'd256,    16'd256, 16'd256, 1'b0, 1'b0, 3'd4, 1'b1},
    '{1'b1, 1'b0, 16'd0,      16'd0,   16'd8,   1'b0, 1'b0, 3'd5, 1'b1},
    '{1'b0, 1'b1, 16'd256,    16'd256, 16'd256, 1'b0, 1'b0, 3'd4, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_we = 1'b0, io_re = 1'b0;
  logic [2:0] io_addr = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic dev_rvalid, dev_rready, dev_wvalid, dev_wready, dev_done, irq;
  logic [15:0] dev_rdata, dev_wdata;

  logic [31:0] mem [1024];
  logic [15:0] sink [512];
  logic bd_we = 1'b0;
  logic [9:0] bd_a = '0;
  logic [31:0] bd_d = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [15:0] cur_seed = '0;
  int cfg_src = 0, cfg_sink = 0, cfg_gen = 0;
  int seen_gen, src_left, sink_left, idx, viol;
  logic done_m, kick = 1'b0;
  logic pend;
  logic [31:0] pend_addr;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  prd_dma_engine uut (
    .clk(clk), .rst(rst), .io_we(io_we), .io_re(io_re), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .dev_rvalid(dev_rvalid), .dev_rready(dev_rready), .dev_rdata(dev_rdata),
    .dev_wvalid(dev_wvalid), .dev_wready(dev_wready), .dev_wdata(dev_wdata),
    .dev_done(dev_done), .irq(irq)
  );

  function automatic logic [15:0] pat(input logic [15:0] s, input int i);
    return s ^ (16'(i) * 16'h0103);
  endfunction

  function automatic logic [31:0] loc(input vec_t v, input int i);
    int h;
    h = int'(v.c0) / 2;
    if (v.two && i >= h) return 32'h400 + 32'(2 * (i - h));
    return 32'(2 * i);
  endfunction

  function automatic logic [15:0] half_at(input logic [31:0] a);
    return a[1] ? mem[a[11:2]][31:16] : mem[a[11:2]][15:0];
  endfunction

  function automatic string vtag(input int k);
    case (k)
      0: return "R6/R4 exact table";
      1: return "R7 short table";
      2: return "R8 long table";
      3: return "R9 stop then done";
      4: return "R7 stop short";
      5: return "R5 memory to device";
      6: return "R3 two descriptors";
      7: return "R12 zero count";
      default: return "R3/R5 chain to device";
    endcase
  endfunction

  assign dev_rvalid = (src_left != 0);
  assign dev_rdata  = pat(cur_seed, idx);
  assign dev_wready = (sink_left != 0);
  assign dev_done   = done_m | kick;

  // memory and device model
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      src_left <= 0; sink_left <= 0; idx <= 0; done_m <= 1'b0;
      seen_gen <= 0; viol <= 0; pend <= 1'b0; pend_addr <= '0;
    end else begin
      done_m <= 1'b0;
      if (bd_we) mem[bd_a] <= bd_d;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_err <= (mem_addr == err_addr);
        if (mem_we && mem_addr != err_addr) begin
          if (mem_addr[1]) mem[mem_addr[11:2]][31:16] <= mem_wdata[15:0];
          else             mem[mem_addr[11:2]][15:0]  <= mem_wdata[15:0];
        end
        mem_rdata <= mem_addr[1] ? {16'h0, mem[mem_addr[11:2]][31:16]}
                                 : mem[mem_addr[11:2]];
      end else begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
      end
      if (pend && mem_req && mem_addr != pend_addr) viol <= viol + 1;
      if (mem_req && (dev_rready || dev_wvalid)) viol <= viol + 1;
      pend      <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
      if (cfg_gen != seen_gen) begin
        seen_gen  <= cfg_gen;
        src_left  <= cfg_src;
        sink_left <= cfg_sink;
        idx       <= 0;
      end else begin
        if (dev_rvalid && dev_rready) begin
          idx <= idx + 1;
          src_left <= src_left - 1;
          if (src_left == 1) done_m <= 1'b1;
        end
        if (dev_wvalid && dev_wready) begin
          sink[idx[8:0]] <= dev_wdata;
          idx <= idx + 1;
          sink_left <= sink_left - 1;
          if (sink_left == 1) done_m <= 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    io_we = 1'b1; io_addr = 3'(a); io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic io_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    io_re = 1'b1; io_addr = 3'(a);
    @(negedge clk);
    io_re = 1'b0;
    d = io_rdata;
  endtask

  task automatic bd_write(input int wa, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_a = 10'(wa); bd_d = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic load_device(input int s, input int k);
    cfg_src = s; cfg_sink = k; cfg_gen++;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input int k);
    vec_t v;
    logic [31:0] s;
    int bad;
    v = VECS[k];
    cur_seed = 16'h0035 + 16'(k) * 16'h1000;
    bd_write(32'h200, 32'h0);
    bd_write(32'h201, {~v.two, 15'd0, v.c0});
    bd_write(32'h202, 32'h400);
    bd_write(32'h203, {1'b1, 15'd0, v.c1});
    if (!v.dir)
      for (int i = 0; i < int'(v.nw); i += 2)
        bd_write(int'(loc(v, i) >> 2), {pat(cur_seed, i + 1), pat(cur_seed, i)});
    load_device(v.dir ? int'(v.nw) : 0, v.dir ? 0 : int'(v.nw));
    io_wr(RP, 32'h800);
    io_wr(RS, 32'h6);
    io_wr(RC, {28'd0, v.dir, 3'b001});
    if (v.abort) io_wr(RC, 32'h0);
    if (v.kick) pulse_done();
    for (int n = 0; n < 20000; n++) begin
      io_rd(RS, s);
      if (!(s[0] && !s[2])) break;
    end
    repeat (20) @(negedge clk);
    io_rd(RS, s);
    check(s[2:0] == v.exp, vtag(k), s, 32'(v.exp));
    check(irq == s[2], {vtag(k), " R10 irq"}, 32'(irq), 32'(s[2]));
    if (v.chk) begin
      bad = 0;
      for (int i = 0; i < int'(v.nw); i++)
        if ((v.dir ? half_at(loc(v, i)) : sink[i]) != pat(cur_seed, i)) bad++;
      check(bad == 0, {vtag(k), " data"}, 32'(bad), 32'd0);
    end
    io_wr(RC, 32'h0);
    io_wr(RS, 32'h6);
    load_device(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!mem_req && !dev_rready && !dev_wvalid, "R1 handshakes idle",
          {29'd0, mem_req, dev_rready, dev_wvalid}, 32'd0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    io_rd(RS, d); check(d == 32'd0, "R1 status", d, 32'd0);
    io_rd(RC, d); check(d == 32'd0, "R1 command", d, 32'd0);
    io_rd(RP, d); check(d == 32'd0, "R1 table base", d, 32'd0);
    // R2 register map
    io_wr(RP, 32'h1234_5678);
    io_rd(RP, d); check(d == 32'h1234_5678, "R2 table base", d, 32'h1234_5678);
    io_wr(RC, 32'h8);
    io_rd(RC, d); check(d == 32'h8, "R2 direction bit", d, 32'h8);
    io_rd(RS, d); check(d == 32'h0, "R2 no start", d, 32'h0);
    io_wr(RC, 32'h0);
    // vector table
    for (int k = 0; k < 9; k++) run_vec(k);
    // R10 interrupt clear rules
    pulse_done();
    io_rd(RS, d); check(d == 32'h4, "R10 done sets interrupt", d, 32'h4);
    check(irq == 1'b1, "R10 irq follows", 32'(irq), 32'd1);
    io_wr(RS, 32'h0);
    io_rd(RS, d); check(d == 32'h4, "R10 write 0 keeps", d, 32'h4);
    io_wr(RS, 32'h2);
    io_rd(RS, d); check(d == 32'h4, "R10 error clear leaves interrupt", d, 32'h4);
    io_wr(RS, 32'h4);
    io_rd(RS, d); check(d == 32'h0, "R10 write 1 clears", d, 32'h0);
    check(irq == 1'b0, "R10 irq cleared", 32'(irq), 32'd0);
    // R11 memory error on count fetch
    bd_write(32'h200, 32'h0);
    bd_write(32'h201, 32'h8000_0200);
    err_addr = 32'h804;
    load_device(256, 0);
    io_wr(RP, 32'h800);
    io_wr(RC, 32'h9);
    repeat (20) @(negedge clk);
    io_rd(RS, d); check(d == 32'h6, "R11 error status", d, 32'h6);
    check(irq == 1'b1, "R11 irq", 32'(irq), 32'd1);
    io_wr(RC, 32'h0);
    io_wr(RS, 32'h6);
    io_rd(RS, d); check(d == 32'h0, "R10 error cleared", d, 32'h0);
    err_addr = 32'hFFFF_FFFF;
    load_device(0, 0);
    // R13 memory protocol watched by the model
    check(viol == 0, "R13 request hold / one side", 32'(viol), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule